// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a parameterised binary down counter. It advances on the rising clock edge. All of its controls are active-low. A master reset drives the register to all ones, not to zero. An asynchronous load copies a preset word into the register at once. A synchronous load captures the same word on the next edge. A count enable gates the decrement.

A terminal-count output goes low while the register holds zero and the count enable is low. Because of this, several counters can be chained: one stage's terminal count drives the count enable of the stage above it. The carry then ripples through zero detectors, and every register in the chain shares the same clock.

When no load is active, a zero count wraps to all ones on the next enabled edge. A free-running stage therefore repeats every 2^WIDTH clocks, which is 256 at the default width of 8.

Top module: `preset_dncnt`

## Requirements
- R1: While `rst_n` is low, `count` is all ones (255 at the default width), immediately and regardless of every other input, including `aload_n`.
- R2: While `rst_n` is high and `aload_n` is low, `count` equals `preset_val` at once, without waiting for a clock edge, regardless of `sload_n`, `cnt_en_n` and the clock.
- R3: With `rst_n` and `aload_n` high and `sload_n` low, `count` takes `preset_val` at the next rising edge, whatever the level of `cnt_en_n`.
- R4: With all loads and reset inactive and `cnt_en_n` low, `count` decreases by exactly one at each rising edge.
- R5: With all loads and reset inactive and `cnt_en_n` high, `count` keeps its value across rising edges.
- R6: With all loads and reset inactive and `cnt_en_n` low, a `count` of zero becomes all ones at the next edge, so a free-running period is 2^WIDTH clocks.
- R7: `tc_n` is low exactly when `count` is zero and `cnt_en_n` is low. It follows a change of `cnt_en_n` within the same cycle, without a clock edge.
- R8: While the counter runs freely, `tc_n` stays low for exactly one clock period per 2^WIDTH clocks.
- R9: The cascade works as follows. A second instance clocked in common has its `cnt_en_n` driven by the first instance's `tc_n`. The second instance then decrements once for each wrap of the first instance. Its `tc_n` goes low only when both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous master reset, active low, sets count to all ones |
| aload_n | input | 1 | Asynchronous load, active low, forces `preset_val` into the counter |
| sload_n | input | 1 | Synchronous load, active low, captures `preset_val` at the next edge |
| cnt_en_n | input | 1 | Count enable, active low; also gates `tc_n` |
| preset_val | input | WIDTH | Preset word used by both loads |
| count | output | WIDTH | Current counter value |
| tc_n | output | 1 | Terminal count, active low, asserted at zero while enabled |

## Verification
The register is the only state in the block, so any wrong internal state appears directly on `count`. A bad decrement, a hold that lets the value drift, or a load that is missed or taken late all show up at the first clock edge after the fault. A wrong precedence among the controls appears within the same cycle as the asynchronous control that exposes it.

A mistake in the zero detection or the enable gating shows on `tc_n` at once. A mistake in the wrap shows one edge after `tc_n` falls. In a cascade, the same mistake also shifts the upper stage's decrement by a full lower period, so the upper count is wrong for up to 256 cycles.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

   // Action selected for the next rising edge
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_DEC  = 2'd1,
      ACT_LOAD = 2'd2
   } dcnt_act_e;

endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
   import dcnt_pkg::*;
(
   input  logic      sload_n,
   input  logic      cnt_en_n,
   output dcnt_act_e act
);

   // Synchronous load outranks counting; the enable is ignored during a load
   always_comb begin
      if (!sload_n)
         act = ACT_LOAD;
      else if (!cnt_en_n)
         act = ACT_DEC;
      else
         act = ACT_HOLD;
   end

endmodule

// File: rtl/dcnt_next.sv
module dcnt_next
   import dcnt_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] preset_val,
   input  dcnt_act_e        act,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   // Modular subtraction gives the zero-to-all-ones wrap for free
   always_comb begin
      unique case (act)
         ACT_LOAD: nxt = preset_val;
         ACT_DEC:  nxt = cur - ONE;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/dcnt_reg.sv
module dcnt_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aload_n,
   input  logic [WIDTH-1:0] preset_val,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   // Reset outranks the asynchronous load, which outranks the clocked path
   always_ff @(posedge clk or negedge rst_n or negedge aload_n) begin
      if (!rst_n)
         q <= ALL_ONES;
      else if (!aload_n)
         q <= preset_val;
      else
         q <= nxt;
   end

endmodule

// File: rtl/dcnt_zero.sv
module dcnt_zero #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] q,
   input  logic             cnt_en_n,
   output logic             tc_n
);

   logic at_zero;

   assign at_zero = ~|q;
   assign tc_n    = ~(at_zero & ~cnt_en_n);

endmodule

// File: rtl/preset_dncnt.sv
module preset_dncnt
   import dcnt_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aload_n,
   input  logic             sload_n,
   input  logic             cnt_en_n,
   input  logic [WIDTH-1:0] preset_val,
   output logic [WIDTH-1:0] count,
   output logic             tc_n
);

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("preset_dncnt: WIDTH must be at least 2");
      end
   endgenerate

   dcnt_act_e        act;
   logic [WIDTH-1:0] nxt;

   dcnt_ctrl u_ctrl (
      .sload_n  (sload_n),
      .cnt_en_n (cnt_en_n),
      .act      (act)
   );

   dcnt_next #(.WIDTH(WIDTH)) u_next (
      .cur        (count),
      .preset_val (preset_val),
      .act        (act),
      .nxt        (nxt)
   );

   dcnt_reg #(.WIDTH(WIDTH)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .aload_n    (aload_n),
      .preset_val (preset_val),
      .nxt        (nxt),
      .q          (count)
   );

   dcnt_zero #(.WIDTH(WIDTH)) u_zero (
      .q        (count),
      .cnt_en_n (cnt_en_n),
      .tc_n     (tc_n)
   );

endmodule

// File: rtl/preset_dncnt_chk.sv
module preset_dncnt_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             aload_n,
   input logic             sload_n,
   input logic             cnt_en_n,
   input logic [WIDTH-1:0] preset_val,
   input logic [WIDTH-1:0] count,
   input logic             tc_n
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

   // Asynchronous controls, sampled mid-cycle
   always @(negedge clk) begin
      if (!rst_n)
         assert_reset_ones_R1: assert (count == ALL_ONES);
      else if (!aload_n)
         assert_async_load_R2: assert (count == preset_val);
   end

   assert_sync_load_R3: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
      !sload_n |=> count == $past(preset_val));

   assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
      (sload_n && !cnt_en_n) |=> count == $past(count) - ONE);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
      (sload_n && cnt_en_n) |=> $stable(count));

   assert_wrap_after_tc_R6: assert property (@(posedge clk) disable iff (!rst_n || !aload_n)
      (!tc_n && sload_n) |=> count == ALL_ONES);

endmodule

bind preset_dncnt preset_dncnt_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .aload_n    (aload_n),
   .sload_n    (sload_n),
   .cnt_en_n   (cnt_en_n),
   .preset_val (preset_val),
   .count      (count),
   .tc_n       (tc_n)
);

// File: tb/preset_dncnt_test.sv
module preset_dncnt_test;

   localparam int W    = 8;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic         aload_n = 1'b1;
   logic         sload_n = 1'b1;
   logic         cnt_en_n = 1'b1;
   logic [W-1:0] preset_val = '0;
   logic         hi_sload_n = 1'b1;
   logic [W-1:0] hi_preset = '0;

   logic [W-1:0] lo_count, hi_count;
   logic         lo_tc_n, hi_tc_n;

   int vectors = 0;
   int miscompares = 0;
   int m_lo = MAXV;
   int m_hi = MAXV;
   bit done = 1'b0;

   always #5 clk = ~clk;

   preset_dncnt #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .aload_n(aload_n), .sload_n(sload_n),
      .cnt_en_n(cnt_en_n), .preset_val(preset_val),
      .count(lo_count), .tc_n(lo_tc_n)
   );

   // Upper stage of the cascade: enable comes from the lower terminal count
   preset_dncnt #(.WIDTH(W)) uut_hi (
      .clk(clk), .rst_n(rst_n), .aload_n(1'b1), .sload_n(hi_sload_n),
      .cnt_en_n(lo_tc_n), .preset_val(hi_preset),
      .count(hi_count), .tc_n(hi_tc_n)
   );

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      int exp_lo_tc, exp_hi_tc;
      exp_lo_tc = (m_lo == 0 && !cnt_en_n) ? 0 : 1;
      exp_hi_tc = (m_hi == 0 && exp_lo_tc == 0) ? 0 : 1;
      chk({tag, " count"}, int'(lo_count), m_lo);
      chk({tag, " tc_n"}, int'(lo_tc_n), exp_lo_tc);
      chk({tag, " hi count R9"}, int'(hi_count), m_hi);
      chk({tag, " hi tc_n R9"}, int'(hi_tc_n), exp_hi_tc);
   endtask

   // One clock: update the reference at the edge, compare mid-cycle
   task automatic tick(input string tag);
      bit lo_tc;
      @(posedge clk);
      lo_tc = (m_lo == 0) && !cnt_en_n;
      if (!rst_n) begin
         m_lo = MAXV;
         m_hi = MAXV;
      end else begin
         if (!aload_n || !sload_n) m_lo = int'(preset_val);
         else if (!cnt_en_n)       m_lo = (m_lo + MAXV) % (MAXV + 1);
         if (!hi_sload_n)          m_hi = int'(hi_preset);
         else if (lo_tc)           m_hi = (m_hi + MAXV) % (MAXV + 1);
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(150000 * 10);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int tc_lows;
      int prev_lo, prev_hi;
      // R1: asynchronous reset to all ones
      #1 rst_n = 1'b0;
      #1 chk("R1 reset value", int'(lo_count), MAXV);
      chk("R1 reset tc_n", int'(lo_tc_n), 1);
      @(negedge clk);
      cnt_en_n = 1'b0;
      aload_n = 1'b0;
      preset_val = 8'h33;
      #1 chk("R1 reset over aload", int'(lo_count), MAXV);
      tick("R1 held in reset");
      aload_n = 1'b1;
      rst_n = 1'b1;

      // R4: decrement
      for (int i = 0; i < 10; i++) tick("R4 decrement");

      // R5: hold
      cnt_en_n = 1'b1;
      for (int i = 0; i < 5; i++) tick("R5 hold");

      // R3: sync load with enable high, then with enable low
      preset_val = 8'd3;
      sload_n = 1'b0;
      tick("R3 load enable high");
      preset_val = 8'd4;
      cnt_en_n = 1'b0;
      tick("R3 load enable low");
      sload_n = 1'b0;
      preset_val = 8'd2;
      tick("R3 load outranks count");
      sload_n = 1'b1;

      // R4/R7/R6: run down to zero and wrap
      tick("R4 to one");
      tick("R7 at zero");
      chk("R7 tc low at zero", int'(lo_tc_n), 0);
      cnt_en_n = 1'b1;
      #1 chk("R7 tc follows enable high", int'(lo_tc_n), 1);
      cnt_en_n = 1'b0;
      #1 chk("R7 tc follows enable low", int'(lo_tc_n), 0);
      tick("R6 wrap");
      chk("R6 wrap to all ones", int'(lo_count), MAXV);

      // R2: asynchronous load, over sync load and enable
      preset_val = 8'h5A;
      aload_n = 1'b0;
      #1 chk("R2 immediate load", int'(lo_count), 8'h5A);
      preset_val = 8'h5A;
      sload_n = 1'b0;
      tick("R2 across edge");
      sload_n = 1'b1;
      aload_n = 1'b1;
      tick("R2 release then R4");

      // R8/R6: full free-running period
      preset_val = 8'd0;
      sload_n = 1'b0;
      tick("R8 load zero");
      sload_n = 1'b1;
      tc_lows = 0;
      for (int i = 0; i < MAXV + 1; i++) begin
         tick("R8 period");
         if (!lo_tc_n) tc_lows++;
      end
      chk("R8 one tc pulse per period", tc_lows, 1);
      chk("R6 back at zero after 256", int'(lo_count), 0);

      // R9: cascade from lo=5, hi=1; total zero after 261 clocks
      preset_val = 8'd5;
      hi_preset = 8'd1;
      sload_n = 1'b0;
      hi_sload_n = 1'b0;
      tick("R9 load both");
      sload_n = 1'b1;
      hi_sload_n = 1'b1;
      tc_lows = 0;
      for (int i = 0; i < 600; i++) begin
         prev_lo = int'(lo_count);
         prev_hi = int'(hi_count);
         tick("R9 cascade");
         if (int'(hi_count) != prev_hi)
            chk("R9 upper steps only after lower zero", prev_lo, 0);
         if (!hi_tc_n) begin
            tc_lows++;
            chk("R9 combined tc at total zero", int'(lo_count) + int'(hi_count), 0);
         end
      end
      chk("R9 one combined terminal count", tc_lows, 1);

      finish_run();
   end

endmodule